// File: doc/BRIEF.md
# Port Pin Interrupt Unit with Per-Pin Flags

This block watches a group of asynchronous input pins and turns selected activity on them into one interrupt request. Each pin first passes through a synchronizer. Each pin also has its own 3-bit trigger field, which picks one of these conditions:

- any edge
- a rising edge only
- a falling edge only
- a low level
- nothing at all

When a pin's condition is seen, that pin's own sticky flag bit is set. The request output is high while any flag is set.

Entering an interrupt clears nothing. Software reads the flag register to learn which pins fired, and clears exactly the bits it has handled by writing ones to them. A flag that is still set, or one set by another pin during the handler, keeps the request asserted, so the handler runs again after it returns. No event on a different pin is lost this way. Repeated events on the same pin are merged while that pin's flag is still set.

The register bus is a plain single-cycle interface with address, write enable, write data and combinational read data. Address 0 is the flag register: a read returns the flags, and a write clears each flag whose data bit is 1. Addresses 1 to NUM_PINS hold the trigger field of pins 0 to NUM_PINS-1.

Top module: `pint_port`

## Requirements
- R1: After reset, all flags are 0, all trigger fields read 0, and irq_o is low.
- R2: With code 2 (rising), a flag is set only by a 0-to-1 change of its pin, never by a 1-to-0 change.
- R3: With code 3 (falling), a flag is set only by a 1-to-0 change of its pin, never by a 0-to-1 change.
- R4: With code 1 (both edges), either change of the pin sets its flag.
- R5: With code 4 (low level), the flag is set on every cycle the synchronized pin is 0, and it cannot stay clear while the pin stays low.
- R6: With code 0, pin activity of any kind never sets that pin's flag.
- R7: irq_o is high exactly while at least one flag is set. It stays high after one flag is cleared if another flag is still set.
- R8: A write to address 0 clears only the flags whose data bits are 1. Bits written as 0 leave their flags unchanged.
- R9: A flag that is already set stays set through further events on its pin. One clear removes it, so the repeated events are merged.
- R10: If a set condition and a write-1 clear reach the same flag in the same cycle, the flag stays set.
- R11: A trigger field reads back the 3-bit value last written to it. Codes 5 to 7 are stored but behave like code 0.
- R12: A pin change made just before clock edge k shows up in its flag, and on irq_o, after edge k+SYNC_STAGES, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | NUM_PINS | Asynchronous pin inputs |
| bus_addr_i | input | ADDR_W | Register address: 0 is the flags, p+1 is the trigger field of pin p |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Combinational read data for bus_addr_i |
| irq_o | output | 1 | Interrupt request, the OR of all flags |

## Verification
The bench builds the block with NUM_PINS=4, SYNC_STAGES=2 and DATA_W=8, which gives ADDR_W=3. With only four pins, every flag bit and every trigger field can be reached by a few directed writes. This includes the case where two pins hold the request together and are cleared one at a time.

Two synchronizer stages make the event latency small. The bench checks the exact edge at which a flag appears, and also checks that it has not appeared one edge earlier.

Because the low-level trigger sets its flag on every cycle, it forces a set and a clear onto the same flag in the same cycle. This is how the set-wins rule can be seen at the ports.

// File: rtl/pint_pkg.sv
package pint_pkg;
  localparam int SENSE_W = 3;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_OFF  = 3'd0,
    SENSE_BOTH = 3'd1,
    SENSE_RISE = 3'd2,
    SENSE_FALL = 3'd3,
    SENSE_LOW  = 3'd4
  } sense_e;
endpackage

// File: rtl/pint_sync.sv
module pint_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pint_detect.sv
module pint_detect
  import pint_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_PINS-1:0]              lvl_i,
  input  logic [NUM_PINS-1:0][SENSE_W-1:0] sense_i,
  output logic [NUM_PINS-1:0]              evt_o
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic rise, fall;
    assign rise = lvl_i[p] & ~prev_q[p];
    assign fall = ~lvl_i[p] & prev_q[p];

    always_comb begin
      unique case (sense_i[p])
        SENSE_BOTH: evt_o[p] = rise | fall;
        SENSE_RISE: evt_o[p] = rise;
        SENSE_FALL: evt_o[p] = fall;
        SENSE_LOW:  evt_o[p] = ~lvl_i[p];
        default:    evt_o[p] = 1'b0; // off and reserved codes
      endcase
    end

    AST_RISE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_o[p] && sense_i[p] == SENSE_RISE) |-> (lvl_i[p] && !$past(lvl_i[p]))); // R2
    AST_FALL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_o[p] && sense_i[p] == SENSE_FALL) |-> (!lvl_i[p] && $past(lvl_i[p]))); // R3
    AST_LOW_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_i[p] == SENSE_LOW && !lvl_i[p]) |-> evt_o[p]); // R5
    AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_i[p] == SENSE_OFF || sense_i[p] > SENSE_LOW) |-> !evt_o[p]); // R6
  end
endmodule

// File: rtl/pint_flags.sv
module pint_flags #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] set_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] flag_o
);
  logic [NUM_PINS-1:0] flag_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign flag_o = flag_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[p] |=> flag_q[p]); // R10
    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[p] && !clr_i[p]) |=> flag_q[p]); // R9
    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[p] && !set_i[p]) |=> !flag_q[p]); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_q[p] && !set_i[p]) |=> !flag_q[p]); // R6
  end
endmodule

// File: rtl/pint_regs.sv
module pint_regs
  import pint_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic                             we_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [DATA_W-1:0]                rdata_o,
  input  logic [NUM_PINS-1:0]              flags_i,
  output logic [NUM_PINS-1:0][SENSE_W-1:0] sense_o,
  output logic [NUM_PINS-1:0]              clr_o
);
  localparam logic [ADDR_W-1:0] FLAG_ADDR = '0;

  logic [NUM_PINS-1:0][SENSE_W-1:0] sense_q;
  logic                             flag_sel;

  assign flag_sel = (addr_i == FLAG_ADDR);
  assign clr_o    = (we_i && flag_sel) ? wdata_i[NUM_PINS-1:0] : '0;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_ctrl
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(p + 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         sense_q[p] <= SENSE_OFF;
      else if (we_i && addr_i == MY_ADDR)  sense_q[p] <= wdata_i[SENSE_W-1:0];
    end

    AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && addr_i == MY_ADDR) |=> $stable(sense_q[p])); // R11
  end

  assign sense_o = sense_q;

  always_comb begin
    rdata_o = '0;
    if (flag_sel) rdata_o[NUM_PINS-1:0] = flags_i;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr_i == ADDR_W'(p + 1)) rdata_o[SENSE_W-1:0] = sense_q[p];
    end
  end
endmodule

// File: rtl/pint_port.sv
module pint_port
  import pint_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = $clog2(NUM_PINS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_we_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0]              lvl;
  logic [NUM_PINS-1:0]              evt;
  logic [NUM_PINS-1:0]              clr;
  logic [NUM_PINS-1:0]              flags;
  logic [NUM_PINS-1:0][SENSE_W-1:0] sense;

  pint_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (lvl)
  );

  pint_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .sense_i(sense),
    .evt_o  (evt)
  );

  pint_flags #(.NUM_PINS(NUM_PINS)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt),
    .clr_i (clr),
    .flag_o(flags)
  );

  pint_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (bus_addr_i),
    .we_i   (bus_we_i),
    .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o),
    .flags_i(flags),
    .sense_o(sense),
    .clr_o  (clr)
  );

  assign irq_o = |flags;

  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|evt)); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && (flags & ~clr) != '0) |=> irq_o); // R7
  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && (flags & ~clr) == '0 && evt == '0) |=> !irq_o); // R7
endmodule

// File: tb/sim_pint_port.sv
`timescale 1ns/1ps
module sim_pint_port;
  localparam int NP = 4;
  localparam int SS = 2;
  localparam int DW = 8;
  localparam int AW = $clog2(NP + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pint_port #(.NUM_PINS(NP), .SYNC_STAGES(SS), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(input int a, input int d);
    @(negedge clk);
    addr = AW'(a); wdata = DW'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input int a, output int d);
    @(negedge clk);
    addr = AW'(a);
    #0.5 d = int'(rdata);
  endtask

  task automatic expect_flags(input string req, input int exp);
    int v;
    bus_rd(0, v);
    check(req, v, exp);
    check(req, int'(irq), int'(exp != 0));
  endtask

  task automatic cleanup();
    for (int p = 0; p < NP; p++) bus_wr(p + 1, 0);
    bus_wr(0, (1 << NP) - 1);
    wait_cyc(1);
  endtask

  task automatic t_reset();
    int v;
    expect_flags("R1", 0);
    for (int p = 0; p < NP; p++) begin
      bus_rd(p + 1, v);
      check("R1", v, 0);
    end
  endtask

  task automatic t_readback();
    int v;
    bus_wr(1, 2); bus_wr(2, 4); bus_wr(4, 7);
    bus_rd(1, v); check("R11", v, 2);
    bus_rd(2, v); check("R11", v, 4);
    bus_rd(3, v); check("R11", v, 0);
    bus_rd(4, v); check("R11", v, 7);
    cleanup();
  endtask

  task automatic t_rise_latency();
    bus_wr(1, 2);
    @(negedge clk) pins[0] = 1'b1;
    repeat (SS) @(posedge clk);
    #0.5 check("R12", int'(irq), 0);
    @(posedge clk);
    #0.5 check("R12", int'(irq), 1);
    expect_flags("R2", 1);
    bus_wr(0, 1);
    @(negedge clk) pins[0] = 1'b0;
    wait_cyc(4);
    expect_flags("R2", 0);
    cleanup();
  endtask

  task automatic t_fall();
    bus_wr(2, 3);
    @(negedge clk) pins[1] = 1'b1;
    wait_cyc(4);
    expect_flags("R3", 0);
    @(negedge clk) pins[1] = 1'b0;
    wait_cyc(4);
    expect_flags("R3", 2);
    cleanup();
  endtask

  task automatic t_both();
    bus_wr(3, 1);
    @(negedge clk) pins[2] = 1'b1;
    wait_cyc(4);
    expect_flags("R4", 4);
    bus_wr(0, 4);
    wait_cyc(1);
    expect_flags("R4", 0);
    @(negedge clk) pins[2] = 1'b0;
    wait_cyc(4);
    expect_flags("R4", 4);
    cleanup();
  endtask

  task automatic t_disabled();
    bus_wr(4, 0);
    @(negedge clk) pins[3] = 1'b1;
    wait_cyc(4);
    @(negedge clk) pins[3] = 1'b0;
    wait_cyc(4);
    expect_flags("R6", 0);
    bus_wr(4, 6);
    @(negedge clk) pins[3] = 1'b1;
    wait_cyc(4);
    @(negedge clk) pins[3] = 1'b0;
    wait_cyc(4);
    expect_flags("R11", 0);
    cleanup();
  endtask

  task automatic t_low_level();
    @(negedge clk) pins[3] = 1'b1;
    wait_cyc(4);
    bus_wr(4, 4);
    wait_cyc(2);
    expect_flags("R5", 0);
    @(negedge clk) pins[3] = 1'b0;
    wait_cyc(4);
    expect_flags("R5", 8);
    bus_wr(0, 8);
    expect_flags("R10", 8);
    @(negedge clk) pins[3] = 1'b1;
    wait_cyc(4);
    expect_flags("R9", 8);
    bus_wr(0, 8);
    wait_cyc(1);
    expect_flags("R5", 0);
    cleanup();
    @(negedge clk) pins[3] = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_multi_irq();
    @(negedge clk) pins[2] = 1'b1;
    wait_cyc(4);
    bus_wr(1, 2); bus_wr(3, 3);
    @(negedge clk) pins[0] = 1'b1;
    wait_cyc(4);
    @(negedge clk) pins[2] = 1'b0;
    wait_cyc(4);
    expect_flags("R7", 5);
    bus_wr(0, 0);
    wait_cyc(1);
    expect_flags("R8", 5);
    bus_wr(0, 1);
    wait_cyc(1);
    expect_flags("R7", 4);
    bus_wr(0, 4);
    wait_cyc(1);
    expect_flags("R7", 0);
    cleanup();
    @(negedge clk) pins[0] = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_merged();
    bus_wr(2, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk) pins[1] = ~pins[1];
      wait_cyc(4);
    end
    expect_flags("R9", 2);
    bus_wr(0, 2);
    wait_cyc(1);
    expect_flags("R9", 0);
    cleanup();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_readback();
    t_rise_latency();
    t_fall();
    t_both();
    t_disabled();
    t_low_level();
    t_multi_irq();
    t_merged();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule